// File: doc/BRIEF.md
# Paired-Page TLB Address Translator

This block turns a virtual address into a physical address by comparing it against every entry of a small, fully associative translation buffer in parallel. Each entry holds one tag that covers two neighbouring pages, an even one and an odd one, with its own base frame and permission bits for each. Every entry carries a page-size mask, so entries of different sizes can sit side by side. The mask also decides which address bit separates the even page from the odd one.

Each cycle the block takes an address, an access type (fetch, load or store), the current address-space identifier and a flag that selects which identifier field is compared. One cycle later it gives a hit flag, the physical address and a 3-bit fault code. Entries are loaded through a single write port. The refill policy that decides what to write lives outside this block.

Top module: `tlbx_translate`

## Requirements
- R1: Reset marks every entry hidden-invalid. A lookup made after reset, and before any write, returns out_hit=0, out_fault=1 and out_pa=0. The same holds after a later reset.
- R2: An entry's tag matches when the tag and the request address agree on every bit above the effective mask. The effective mask is the entry's page mask ORed with the low PAGE_BITS+1 bits set. Address bits inside the mask do not affect the match.
- R3: An entry takes part only if its hidden-invalid flag is clear and it is either global or its identifier matches. With req_mmid_mode=1 the 16-bit map identifier is compared against req_id. With req_mmid_mode=0 the 8-bit ASID is compared against req_id[7:0].
- R4: The half is picked by the address bit at (effective mask >> 1) + 1: 0 selects the even frame and 1 selects the odd frame. out_pa is the selected frame base ORed with the address ANDed with the effective mask >> 1.
- R5: On a hit whose selected half has its valid bit clear, out_fault=2 for every access type. This takes precedence over all other permission faults. Permission nibble: bit0 valid, bit1 dirty, bit2 execute-inhibit, bit3 read-inhibit.
- R6: With req_acc=0 (fetch) and execute-inhibit set, out_fault=4. With req_acc=1 (load) and read-inhibit set, out_fault=5. Each inhibit bit has no effect on the other access types.
- R7: With req_acc=2 (store) and the dirty bit clear, out_fault=3. Fetch and load succeed whatever the dirty bit is. Every other hit gives out_fault=0.
- R8: When no entry takes part and matches, out_hit=0, out_fault=1 and out_pa=0.
- R9: When several entries match, the one with the lowest index is used.
- R10: Results are registered and appear one cycle after the request. A write is seen by lookups issued on the cycle after it, and not by a lookup issued on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vpn | input | VA_W | Tag (virtual page pair base) |
| wr_pmask | input | VA_W | Page-size mask |
| wr_asid | input | ASID_W | Address-space identifier of the entry |
| wr_mmid | input | MMID_W | Map identifier of the entry |
| wr_global | input | 1 | Entry matches every identifier |
| wr_hinv | input | 1 | Hidden-invalid flag |
| wr_pfn0 | input | PA_W | Even page frame base |
| wr_pfn1 | input | PA_W | Odd page frame base |
| wr_perm0 | input | 4 | Even page permissions {ri, xi, dirty, valid} |
| wr_perm1 | input | 4 | Odd page permissions {ri, xi, dirty, valid} |
| req_va | input | VA_W | Virtual address to translate |
| req_acc | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| req_id | input | MMID_W | Current identifier |
| req_mmid_mode | input | 1 | 1 compares the map identifier, 0 compares the ASID |
| out_hit | output | 1 | An entry matched |
| out_fault | output | 3 | 0 ok, 1 no match, 2 invalid, 3 modified, 4 exec-inhibit, 5 read-inhibit |
| out_pa | output | PA_W | Physical address (0 on a miss) |

## Verification
The hardest case to reach is several entries matching at once. The priority rule shows up only when the lower-index winner is removed and the result moves to the next entry. The stimulus loads a duplicate of an existing tag at a higher index and checks that the low entry wins. It then rewrites the low entry as hidden-invalid and checks that the higher entry's frame comes out. A large page entry checks that the select bit moves with the mask: an address with bit 12 set stays in the even half, while bit 16 reaches the odd half.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_MISS     = 3'd1,
    FLT_INVALID  = 3'd2,
    FLT_MODIFIED = 3'd3,
    FLT_EXEC     = 3'd4,
    FLT_READ     = 3'd5
  } fault_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  localparam int PERM_V  = 0;
  localparam int PERM_D  = 1;
  localparam int PERM_XI = 2;
  localparam int PERM_RI = 3;
endpackage

// File: rtl/tlbx_way_match.sv
module tlbx_way_match #(
  parameter int VA_W      = 32,
  parameter int ASID_W    = 8,
  parameter int MMID_W    = 16,
  parameter int PAGE_BITS = 12
) (
  input  logic [VA_W-1:0]   vpn,
  input  logic [VA_W-1:0]   pmask,
  input  logic [ASID_W-1:0] asid,
  input  logic [MMID_W-1:0] mmid,
  input  logic              glob,
  input  logic              hinv,
  input  logic [VA_W-1:0]   va,
  input  logic [MMID_W-1:0] id,
  input  logic              mmode,
  output logic              hit,
  output logic              odd,
  output logic [VA_W-1:0]   offs
);
  localparam logic [VA_W-1:0] BASE_MASK =
    {{(VA_W-PAGE_BITS-1){1'b0}}, {(PAGE_BITS+1){1'b1}}};

  logic [VA_W-1:0] emask;
  logic [VA_W-1:0] half;
  logic [VA_W-1:0] selbit;
  logic            tag_ok;
  logic            id_ok;

  always_comb begin
    emask  = pmask | BASE_MASK;
    half   = emask >> 1;
    selbit = half + 1'b1;
    odd    = |(va & selbit);
    offs   = va & half;
    tag_ok = (vpn & ~emask) == (va & ~emask);
    id_ok  = mmode ? (mmid == id) : (asid == id[ASID_W-1:0]);
    hit    = tag_ok && (glob || id_ok) && !hinv;
  end
endmodule

// File: rtl/tlbx_prio.sv
module tlbx_prio #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlbx_translate.sv
module tlbx_translate #(
  parameter int ENTRIES   = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 36,
  parameter int ASID_W    = 8,
  parameter int MMID_W    = 16,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_vpn,
  input  logic [VA_W-1:0]   wr_pmask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [MMID_W-1:0] wr_mmid,
  input  logic              wr_global,
  input  logic              wr_hinv,
  input  logic [PA_W-1:0]   wr_pfn0,
  input  logic [PA_W-1:0]   wr_pfn1,
  input  logic [3:0]        wr_perm0,
  input  logic [3:0]        wr_perm1,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_acc,
  input  logic [MMID_W-1:0] req_id,
  input  logic              req_mmid_mode,
  output logic              out_hit,
  output logic [2:0]        out_fault,
  output logic [PA_W-1:0]   out_pa
);
  import tlbx_pkg::*;

  logic [VA_W-1:0]   e_vpn   [ENTRIES];
  logic [VA_W-1:0]   e_pmask [ENTRIES];
  logic [ASID_W-1:0] e_asid  [ENTRIES];
  logic [MMID_W-1:0] e_mmid  [ENTRIES];
  logic [PA_W-1:0]   e_pfn0  [ENTRIES];
  logic [PA_W-1:0]   e_pfn1  [ENTRIES];
  logic [3:0]        e_perm0 [ENTRIES];
  logic [3:0]        e_perm1 [ENTRIES];
  logic [ENTRIES-1:0] e_glob;
  logic [ENTRIES-1:0] e_hinv;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      e_vpn[wr_idx]   <= wr_vpn;
      e_pmask[wr_idx] <= wr_pmask;
      e_asid[wr_idx]  <= wr_asid;
      e_mmid[wr_idx]  <= wr_mmid;
      e_pfn0[wr_idx]  <= wr_pfn0;
      e_pfn1[wr_idx]  <= wr_pfn1;
      e_perm0[wr_idx] <= wr_perm0;
      e_perm1[wr_idx] <= wr_perm1;
      e_glob[wr_idx]  <= wr_global;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e_hinv <= '1;
    end else if (wr_en) begin
      e_hinv[wr_idx] <= wr_hinv;
    end
  end

  logic [ENTRIES-1:0] way_hit;
  logic [ENTRIES-1:0] way_odd;
  logic [VA_W-1:0]    way_offs [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_way
    tlbx_way_match #(
      .VA_W(VA_W), .ASID_W(ASID_W), .MMID_W(MMID_W), .PAGE_BITS(PAGE_BITS)
    ) u_match (
      .vpn   (e_vpn[g]),
      .pmask (e_pmask[g]),
      .asid  (e_asid[g]),
      .mmid  (e_mmid[g]),
      .glob  (e_glob[g]),
      .hinv  (e_hinv[g]),
      .va    (req_va),
      .id    (req_id),
      .mmode (req_mmid_mode),
      .hit   (way_hit[g]),
      .odd   (way_odd[g]),
      .offs  (way_offs[g])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] win;

  tlbx_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
    .req (way_hit),
    .any (any_hit),
    .idx (win)
  );

  logic [3:0]      sel_perm;
  logic [PA_W-1:0] sel_base;
  logic [PA_W-1:0] pa_nxt;
  fault_e          flt_nxt;

  always_comb begin
    sel_perm = way_odd[win] ? e_perm1[win] : e_perm0[win];
    sel_base = way_odd[win] ? e_pfn1[win]  : e_pfn0[win];
    pa_nxt   = any_hit ? (sel_base | PA_W'(way_offs[win])) : '0;
    if (!any_hit)
      flt_nxt = FLT_MISS;
    else if (!sel_perm[PERM_V])
      flt_nxt = FLT_INVALID;
    else if (req_acc == ACC_FETCH && sel_perm[PERM_XI])
      flt_nxt = FLT_EXEC;
    else if (req_acc == ACC_LOAD && sel_perm[PERM_RI])
      flt_nxt = FLT_READ;
    else if (req_acc == ACC_STORE && !sel_perm[PERM_D])
      flt_nxt = FLT_MODIFIED;
    else
      flt_nxt = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_hit   <= 1'b0;
      out_fault <= FLT_MISS;
      out_pa    <= '0;
    end else begin
      out_hit   <= any_hit;
      out_fault <= flt_nxt;
      out_pa    <= pa_nxt;
    end
  end
endmodule

// File: rtl/tlbx_translate_chk.sv
module tlbx_translate_chk #(
  parameter int PA_W = 36
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      req_acc,
  input logic            out_hit,
  input logic [2:0]      out_fault,
  input logic [PA_W-1:0] out_pa
);
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_hit); // R1
  AST_HIT_NOT_MISS: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> out_fault != 3'd1); // R2
  AST_MISS_CODE: assert property (@(posedge clk) disable iff (rst)
    !out_hit |-> out_fault == 3'd1); // R8
  AST_MISS_PA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_hit |-> out_pa == '0); // R8
  AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    out_fault <= 3'd5); // R5
  AST_EXEC_ON_FETCH: assert property (@(posedge clk) disable iff (rst)
    out_fault == 3'd4 |-> $past(req_acc) == 2'd0); // R6
  AST_READ_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    out_fault == 3'd5 |-> $past(req_acc) == 2'd1); // R6
  AST_MOD_ON_STORE: assert property (@(posedge clk) disable iff (rst)
    out_fault == 3'd3 |-> $past(req_acc) == 2'd2); // R7
endmodule

bind tlbx_translate tlbx_translate_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/test_tlbx_translate.sv
module test_tlbx_translate;
  localparam int VA_W = 32;
  localparam int PA_W = 36;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [2:0]      wr_idx = '0;
  logic [31:0]     wr_vpn = '0, wr_pmask = '0;
  logic [7:0]      wr_asid = '0;
  logic [15:0]     wr_mmid = '0;
  logic            wr_global = 1'b0, wr_hinv = 1'b0;
  logic [35:0]     wr_pfn0 = '0, wr_pfn1 = '0;
  logic [3:0]      wr_perm0 = '0, wr_perm1 = '0;
  logic [31:0]     req_va = '0;
  logic [1:0]      req_acc = '0;
  logic [15:0]     req_id = '0;
  logic            req_mmid_mode = 1'b0;
  logic            out_hit;
  logic [2:0]      out_fault;
  logic [35:0]     out_pa;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tlbx_translate i_tlbx_translate (.*);

  task automatic chk(input string tag, input logic [35:0] got, input logic [35:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic put(input int idx, input logic [31:0] vpn, input logic [31:0] pm,
                     input logic [7:0] asid, input logic [15:0] mmid, input logic g,
                     input logic hi, input logic [35:0] p0, input logic [35:0] p1,
                     input logic [3:0] m0, input logic [3:0] m1);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_vpn = vpn; wr_pmask = pm; wr_asid = asid;
    wr_mmid = mmid; wr_global = g; wr_hinv = hi; wr_pfn0 = p0; wr_pfn1 = p1;
    wr_perm0 = m0; wr_perm1 = m1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input string tag, input logic [31:0] va, input logic [1:0] acc,
                      input logic [15:0] id, input logic mm, input logic eh,
                      input logic [2:0] ef, input logic [35:0] epa, input logic cpa);
    @(negedge clk);
    req_va = va; req_acc = acc; req_id = id; req_mmid_mode = mm;
    @(negedge clk);
    chk({tag, " hit"}, 36'(out_hit), 36'(eh));
    chk({tag, " fault"}, 36'(out_fault), 36'(ef));
    if (cpa) chk({tag, " pa"}, out_pa, epa);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    look("R1 empty", 32'h1000_5678, 2'd0, 16'd9, 1'b0, 1'b0, 3'd1, 36'h0, 1'b1);
  endtask

  task automatic t_small_pair;
    put(0, 32'h0040_0000, 32'h0, 8'h05, 16'h0, 1'b0, 1'b0,
        36'h1_2345_6000, 36'h0_ABCD_E000, 4'b0011, 4'b0101);
    look("R4 even", 32'h0040_0ABC, 2'd1, 16'd5, 1'b0, 1'b1, 3'd0, 36'h1_2345_6ABC, 1'b1);
    look("R7 even store ok", 32'h0040_0ABC, 2'd2, 16'd5, 1'b0, 1'b1, 3'd0, 36'h1_2345_6ABC, 1'b1);
    look("R4 odd load", 32'h0040_1ABC, 2'd1, 16'd5, 1'b0, 1'b1, 3'd0, 36'h0_ABCD_EABC, 1'b1);
    look("R7 odd store", 32'h0040_1ABC, 2'd2, 16'd5, 1'b0, 1'b1, 3'd3, 36'h0, 1'b0);
    look("R6 odd fetch", 32'h0040_1ABC, 2'd0, 16'd5, 1'b0, 1'b1, 3'd4, 36'h0, 1'b0);
    look("R2 beyond pair", 32'h0040_2ABC, 2'd1, 16'd5, 1'b0, 1'b0, 3'd1, 36'h0, 1'b1);
    look("R3 asid differs", 32'h0040_0ABC, 2'd1, 16'd6, 1'b0, 1'b0, 3'd1, 36'h0, 1'b1);
  endtask

  task automatic t_large_page;
    put(1, 32'h1000_0000, 32'h0001_E000, 8'h00, 16'h0, 1'b1, 1'b0,
        36'h2_0000_0000, 36'h3_0000_0000, 4'b1011, 4'b0000);
    look("R3 global fetch", 32'h1000_5678, 2'd0, 16'd9, 1'b0, 1'b1, 3'd0, 36'h2_0000_5678, 1'b1);
    look("R6 read inhibit", 32'h1000_5678, 2'd1, 16'd9, 1'b0, 1'b1, 3'd5, 36'h0, 1'b0);
    look("R2 masked bits", 32'h1000_F000, 2'd0, 16'd9, 1'b0, 1'b1, 3'd0, 36'h2_0000_F000, 1'b1);
    look("R5 odd invalid", 32'h1001_2345, 2'd0, 16'd9, 1'b0, 1'b1, 3'd2, 36'h0, 1'b0);
    look("R5 invalid store", 32'h1001_2345, 2'd2, 16'd9, 1'b0, 1'b1, 3'd2, 36'h0, 1'b0);
    look("R8 large miss", 32'h1002_0000, 2'd0, 16'd9, 1'b0, 1'b0, 3'd1, 36'h0, 1'b1);
  endtask

  task automatic t_identity;
    put(2, 32'h0080_0000, 32'h0, 8'h07, 16'h0ABC, 1'b0, 1'b0,
        36'h4_0000_0000, 36'h4_0000_1000, 4'b0011, 4'b0011);
    look("R3 mmid match", 32'h0080_0010, 2'd1, 16'h0ABC, 1'b1, 1'b1, 3'd0, 36'h4_0000_0010, 1'b1);
    look("R3 asid match", 32'h0080_0010, 2'd1, 16'h0007, 1'b0, 1'b1, 3'd0, 36'h4_0000_0010, 1'b1);
    look("R3 mmid mode miss", 32'h0080_0010, 2'd1, 16'h0007, 1'b1, 1'b0, 3'd1, 36'h0, 1'b1);
    look("R3 asid mode miss", 32'h0080_0010, 2'd1, 16'h0ABC, 1'b0, 1'b0, 3'd1, 36'h0, 1'b1);
    put(3, 32'h00C0_0000, 32'h0, 8'h00, 16'h0, 1'b1, 1'b1,
        36'h7_0000_0000, 36'h7_0000_1000, 4'b0011, 4'b0011);
    look("R3 hidden invalid", 32'h00C0_0000, 2'd1, 16'h0, 1'b0, 1'b0, 3'd1, 36'h0, 1'b1);
  endtask

  task automatic t_priority;
    put(4, 32'h0040_0000, 32'h0, 8'h05, 16'h0, 1'b0, 1'b0,
        36'h5_5555_5000, 36'h5_5555_6000, 4'b0011, 4'b0011);
    look("R9 low wins", 32'h0040_0ABC, 2'd1, 16'd5, 1'b0, 1'b1, 3'd0, 36'h1_2345_6ABC, 1'b1);
    put(0, 32'h0040_0000, 32'h0, 8'h05, 16'h0, 1'b0, 1'b1,
        36'h1_2345_6000, 36'h0_ABCD_E000, 4'b0011, 4'b0101);
    look("R9 next wins", 32'h0040_0ABC, 2'd1, 16'd5, 1'b0, 1'b1, 3'd0, 36'h5_5555_5ABC, 1'b1);
  endtask

  task automatic t_latency;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd5; wr_vpn = 32'h2000_0000; wr_pmask = '0; wr_asid = '0;
    wr_mmid = '0; wr_global = 1'b1; wr_hinv = 1'b0; wr_pfn0 = 36'h6_0000_0000;
    wr_pfn1 = 36'h6_0000_1000; wr_perm0 = 4'b0011; wr_perm1 = 4'b0011;
    req_va = 32'h2000_0123; req_acc = 2'd1; req_id = '0; req_mmid_mode = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 same cycle miss", 36'(out_hit), 36'h0);
    @(negedge clk);
    chk("R10 next cycle hit", 36'(out_hit), 36'h1);
    chk("R10 next cycle pa", out_pa, 36'h6_0000_0123);
  endtask

  initial begin
    t_reset;
    t_small_pair;
    t_large_page;
    t_identity;
    t_priority;
    t_latency;
    t_reset;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule